// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel LCD panel that is driven by one pixel clock and keys its pixel capture on a data-enable strobe. A horizontal counter advances once per clock. A vertical counter advances each time the horizontal counter wraps. The live coordinates go out on `x_o` / `y_o`, and downstream logic uses them to compute pixel colour.

Data-enable, horizontal sync, vertical sync and a one-clock frame-start marker are decoded from the coordinates. The visible picture begins at coordinate (0,0), and all blanking and sync sit after the visible region. The four strobes then pass through a register pipeline of `PIPE_DELAY` stages. Set `PIPE_DELAY` to the latency of the pixel path, such as the read latency of a frame RAM, and the strobes arrive at the panel in the same cycle as the pixel they describe.

The frame geometry, the sync windows and the sync polarities are all parameters. The defaults give 1024 clocks per line and 525 lines per frame, with an 800x480 visible area.

Top module: `lcd_raster_gen`

## Requirements
- R1: `x_o` advances by one on every clock, and after `H_TOTAL-1` it returns to 0. The default `H_TOTAL` is 1024.
- R2: `y_o` changes only on the clock where `x_o` wraps. At that clock it advances by one, or returns to 0 from `V_TOTAL-1`. The default `V_TOTAL` is 525.
- R3: While `rst_ni` is low, both counters are 0 at once, without waiting for a clock. Every pipeline stage also holds the idle value: data-enable low, both syncs at their inactive level and frame-start low.
- R4: Data-enable is asserted for a coordinate exactly when x < `H_ACTIVE` and y < `V_ACTIVE`. With the defaults (800, 480) the visible area runs from (0,0) to (799,479).
- R5: Horizontal sync is active for a coordinate exactly when `HS_START` <= x < `HS_END`. The defaults are 816 and 848.
- R6: Vertical sync is active for a coordinate exactly when `VS_START` <= y < `VS_END`. The defaults are 482 and 485.
- R7: Frame-start is high for the single coordinate (0,0) and low for every other coordinate.
- R8: Each output strobe takes, `PIPE_DELAY` clocks after a coordinate appears on `x_o`/`y_o`, the value decoded for that coordinate. `PIPE_DELAY` ranges from 0 to 4. With 0, the strobes are combinational from the current coordinates. Before `PIPE_DELAY` clocks have passed since reset, the strobes carry the idle value.
- R9: An active sync drives its output to the value of `HS_ACT_HIGH` / `VS_ACT_HIGH`, and an inactive sync drives the inverse. Setting the parameter to 1 gives active-high, and 0 gives active-low.
- R10: A 1000x500 total frame is supported (x wraps after 999, y after 499) with the same visible area and sync windows. This is the frame that gives 60 Hz at a 30 MHz pixel clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| x_o | output | XW = clog2(H_TOTAL) | Current horizontal coordinate (undelayed) |
| y_o | output | YW = clog2(V_TOTAL) | Current vertical coordinate (undelayed) |
| de_o | output | 1 | Data-enable, delayed by `PIPE_DELAY` |
| hs_o | output | 1 | Horizontal sync, delayed, polarity per `HS_ACT_HIGH` |
| vs_o | output | 1 | Vertical sync, delayed, polarity per `VS_ACT_HIGH` |
| frame_start_o | output | 1 | One-clock pulse for coordinate (0,0), delayed |

## Verification
The bench builds five copies side by side.

- **Default parameters** (pipeline depth 1): covers the 1023 wrap, the 799/800 data-enable edge and the 816–848 sync window over three full lines.
- **Shrunken 40x12 geometry at depths 0, 2 and 4**: a whole frame lasts 480 clocks, so the vertical wrap, vertical sync and the frame-start pulse recur several times. The depth-0 copy also has both syncs active-low, which covers the combinational path and the polarity inversion together.
- **1000x500 geometry at depth 3**: covers the alternative wrap point.

A reset applied mid-frame shows the asynchronous clear and the idle pipeline fill on all five copies.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
    logic fs;
  } raster_flags_t;

endpackage

// File: rtl/lcd_axis_counter.sv
module lcd_axis_counter #(
  parameter int unsigned TOTAL = 1024,
  parameter int unsigned W     = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] pos_o
);

  localparam logic [W-1:0] LAST = W'(TOTAL - 1);

  logic [W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (step_i) begin
      pos_q <= (pos_q == LAST) ? '0 : pos_q + W'(1);
    end
  end

  assign pos_o = pos_q;

endmodule

// File: rtl/lcd_flag_decode.sv
module lcd_flag_decode
  import lcd_raster_pkg::*;
#(
  parameter int unsigned XW          = 10,
  parameter int unsigned YW          = 10,
  parameter int unsigned H_ACTIVE    = 800,
  parameter int unsigned V_ACTIVE    = 480,
  parameter int unsigned HS_START    = 816,
  parameter int unsigned HS_END      = 848,
  parameter int unsigned VS_START    = 482,
  parameter int unsigned VS_END      = 485,
  parameter bit          HS_ACT_HIGH = 1'b1,
  parameter bit          VS_ACT_HIGH = 1'b1
) (
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  output raster_flags_t flags_o
);

  logic [31:0] xe, ye;
  logic        hs_on, vs_on;

  // widen so window limits equal to the total still compare correctly
  assign xe = 32'(x_i);
  assign ye = 32'(y_i);

  assign hs_on = (xe >= HS_START) && (xe < HS_END);
  assign vs_on = (ye >= VS_START) && (ye < VS_END);

  always_comb begin
    flags_o.de = (xe < H_ACTIVE) && (ye < V_ACTIVE);
    flags_o.hs = hs_on ? HS_ACT_HIGH : ~HS_ACT_HIGH;
    flags_o.vs = vs_on ? VS_ACT_HIGH : ~VS_ACT_HIGH;
    flags_o.fs = (xe == 32'd0) && (ye == 32'd0);
  end

endmodule

// File: rtl/lcd_delay_line.sv
module lcd_delay_line
  import lcd_raster_pkg::*;
#(
  parameter int unsigned   DEPTH = 1,
  parameter raster_flags_t IDLE  = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  raster_flags_t d_i,
  output raster_flags_t q_o
);

  if (DEPTH == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_pipe
    raster_flags_t stg_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) stg_q[i] <= IDLE;
      end else begin
        stg_q[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
      end
    end

    assign q_o = stg_q[DEPTH-1];
  end

endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_raster_pkg::*;
#(
  parameter int unsigned H_TOTAL     = 1024,
  parameter int unsigned V_TOTAL     = 525,
  parameter int unsigned H_ACTIVE    = 800,
  parameter int unsigned V_ACTIVE    = 480,
  parameter int unsigned HS_START    = 816,
  parameter int unsigned HS_END      = 848,
  parameter int unsigned VS_START    = 482,
  parameter int unsigned VS_END      = 485,
  parameter int unsigned PIPE_DELAY  = 1,
  parameter bit          HS_ACT_HIGH = 1'b1,
  parameter bit          VS_ACT_HIGH = 1'b1,
  localparam int unsigned XW = (H_TOTAL > 1) ? $clog2(H_TOTAL) : 1,
  localparam int unsigned YW = (V_TOTAL > 1) ? $clog2(V_TOTAL) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          de_o,
  output logic          hs_o,
  output logic          vs_o,
  output logic          frame_start_o
);

  localparam logic [XW-1:0] H_LAST = XW'(H_TOTAL - 1);
  localparam raster_flags_t IDLE = '{de: 1'b0, hs: ~HS_ACT_HIGH, vs: ~VS_ACT_HIGH, fs: 1'b0};

  if (PIPE_DELAY > 4) begin : g_bad_depth
    $error("PIPE_DELAY must be 0..4");
  end

  logic          h_wrap;
  raster_flags_t raw_flags, out_flags;

  lcd_axis_counter #(.TOTAL(H_TOTAL), .W(XW)) u_hcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (1'b1),
    .pos_o  (x_o)
  );

  assign h_wrap = (x_o == H_LAST);

  lcd_axis_counter #(.TOTAL(V_TOTAL), .W(YW)) u_vcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (h_wrap),
    .pos_o  (y_o)
  );

  lcd_flag_decode #(
    .XW(XW), .YW(YW),
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
    .HS_START(HS_START), .HS_END(HS_END),
    .VS_START(VS_START), .VS_END(VS_END),
    .HS_ACT_HIGH(HS_ACT_HIGH), .VS_ACT_HIGH(VS_ACT_HIGH)
  ) u_dec (
    .x_i     (x_o),
    .y_i     (y_o),
    .flags_o (raw_flags)
  );

  lcd_delay_line #(.DEPTH(PIPE_DELAY), .IDLE(IDLE)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_flags),
    .q_o    (out_flags)
  );

  assign de_o          = out_flags.de;
  assign hs_o          = out_flags.hs;
  assign vs_o          = out_flags.vs;
  assign frame_start_o = out_flags.fs;

endmodule

// File: rtl/lcd_raster_gen_chk.sv
module lcd_raster_gen_chk #(
  parameter int unsigned H_TOTAL     = 1024,
  parameter int unsigned V_TOTAL     = 525,
  parameter bit          HS_ACT_HIGH = 1'b1,
  parameter bit          VS_ACT_HIGH = 1'b1,
  localparam int unsigned XW = (H_TOTAL > 1) ? $clog2(H_TOTAL) : 1,
  localparam int unsigned YW = (V_TOTAL > 1) ? $clog2(V_TOTAL) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [XW-1:0] x_o,
  input logic [YW-1:0] y_o,
  input logic          de_o,
  input logic          hs_o,
  input logic          vs_o,
  input logic          frame_start_o
);

  localparam logic [XW-1:0] H_LAST = XW'(H_TOTAL - 1);
  localparam logic [YW-1:0] V_LAST = YW'(V_TOTAL - 1);

  // R1
  x_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_o != H_LAST) |=> (x_o == $past(x_o) + XW'(1)));

  // R1
  x_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_o == H_LAST) |=> (x_o == '0));

  // R2
  y_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_o != H_LAST) |=> $stable(y_o));

  // R2
  y_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_o == H_LAST && y_o != V_LAST) |=> (y_o == $past(y_o) + YW'(1)));

  // R2
  y_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_o == H_LAST && y_o == V_LAST) |=> (y_o == '0));

  // R5
  de_hs_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (hs_o != HS_ACT_HIGH));

  // R6
  de_vs_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (vs_o != VS_ACT_HIGH));

  // R7
  fs_in_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> de_o);

  // R7
  fs_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

endmodule

bind lcd_raster_gen lcd_raster_gen_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
  .HS_ACT_HIGH(HS_ACT_HIGH), .VS_ACT_HIGH(VS_ACT_HIGH)
) u_chk (.*);

// File: tb/lcd_raster_gen_test.sv
module lcd_raster_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  // index: 0 default, 1 small d0 active-low, 2 small d2, 3 small d4, 4 alt 1000x500 d3
  localparam int HT [N] = '{1024, 40, 40, 40, 1000};
  localparam int VT [N] = '{525, 12, 12, 12, 500};
  localparam int HA [N] = '{800, 20, 20, 20, 800};
  localparam int VA [N] = '{480, 8, 8, 8, 480};
  localparam int HS0[N] = '{816, 24, 24, 24, 816};
  localparam int HS1[N] = '{848, 28, 28, 28, 848};
  localparam int VS0[N] = '{482, 9, 9, 9, 482};
  localparam int VS1[N] = '{485, 10, 10, 10, 485};
  localparam int DL [N] = '{1, 0, 2, 4, 3};
  localparam bit HP [N] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam bit VP [N] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cnt;
  int   n_tests = 0;
  int   n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench-side elapsed-clock count since reset release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 0;
    else        cnt <= cnt + 1;
  end

  logic [9:0] x0, y0;
  logic [5:0] x1, x2, x3;
  logic [3:0] y1, y2, y3;
  logic [9:0] x4;
  logic [8:0] y4;
  logic [N-1:0] de, hs, vs, fs;

  lcd_raster_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .x_o(x0), .y_o(y0),
    .de_o(de[0]), .hs_o(hs[0]), .vs_o(vs[0]), .frame_start_o(fs[0]));

  lcd_raster_gen #(.H_TOTAL(HT[1]), .V_TOTAL(VT[1]), .H_ACTIVE(HA[1]), .V_ACTIVE(VA[1]),
    .HS_START(HS0[1]), .HS_END(HS1[1]), .VS_START(VS0[1]), .VS_END(VS1[1]),
    .PIPE_DELAY(DL[1]), .HS_ACT_HIGH(HP[1]), .VS_ACT_HIGH(VP[1])) uut_d0 (
    .clk_i(clk), .rst_ni(rst_n), .x_o(x1), .y_o(y1),
    .de_o(de[1]), .hs_o(hs[1]), .vs_o(vs[1]), .frame_start_o(fs[1]));

  lcd_raster_gen #(.H_TOTAL(HT[2]), .V_TOTAL(VT[2]), .H_ACTIVE(HA[2]), .V_ACTIVE(VA[2]),
    .HS_START(HS0[2]), .HS_END(HS1[2]), .VS_START(VS0[2]), .VS_END(VS1[2]),
    .PIPE_DELAY(DL[2]), .HS_ACT_HIGH(HP[2]), .VS_ACT_HIGH(VP[2])) uut_d2 (
    .clk_i(clk), .rst_ni(rst_n), .x_o(x2), .y_o(y2),
    .de_o(de[2]), .hs_o(hs[2]), .vs_o(vs[2]), .frame_start_o(fs[2]));

  lcd_raster_gen #(.H_TOTAL(HT[3]), .V_TOTAL(VT[3]), .H_ACTIVE(HA[3]), .V_ACTIVE(VA[3]),
    .HS_START(HS0[3]), .HS_END(HS1[3]), .VS_START(VS0[3]), .VS_END(VS1[3]),
    .PIPE_DELAY(DL[3]), .HS_ACT_HIGH(HP[3]), .VS_ACT_HIGH(VP[3])) uut_d4 (
    .clk_i(clk), .rst_ni(rst_n), .x_o(x3), .y_o(y3),
    .de_o(de[3]), .hs_o(hs[3]), .vs_o(vs[3]), .frame_start_o(fs[3]));

  lcd_raster_gen #(.H_TOTAL(HT[4]), .V_TOTAL(VT[4]), .H_ACTIVE(HA[4]), .V_ACTIVE(VA[4]),
    .HS_START(HS0[4]), .HS_END(HS1[4]), .VS_START(VS0[4]), .VS_END(VS1[4]),
    .PIPE_DELAY(DL[4]), .HS_ACT_HIGH(HP[4]), .VS_ACT_HIGH(VP[4])) uut_alt (
    .clk_i(clk), .rst_ni(rst_n), .x_o(x4), .y_o(y4),
    .de_o(de[4]), .hs_o(hs[4]), .vs_o(vs[4]), .frame_start_o(fs[4]));

  int gx [N];
  int gy [N];
  always_comb begin
    gx[0] = int'(x0); gy[0] = int'(y0);
    gx[1] = int'(x1); gy[1] = int'(y1);
    gx[2] = int'(x2); gy[2] = int'(y2);
    gx[3] = int'(x3); gy[3] = int'(y3);
    gx[4] = int'(x4); gy[4] = int'(y4);
  end

  typedef struct {
    int x;
    int y;
    bit de;
    bit hs;
    bit vs;
    bit fs;
  } exp_t;

  // expected outputs k clocks after reset release, from the requirement text
  function automatic exp_t model(int k, int i);
    exp_t e;
    int   px, py;
    e.x = k % HT[i];
    e.y = (k / HT[i]) % VT[i];
    if (k < DL[i]) begin
      e.de = 1'b0; e.hs = ~HP[i]; e.vs = ~VP[i]; e.fs = 1'b0;
    end else begin
      px = (k - DL[i]) % HT[i];
      py = ((k - DL[i]) / HT[i]) % VT[i];
      e.de = (px < HA[i]) && (py < VA[i]);
      e.hs = (px >= HS0[i] && px < HS1[i]) ? HP[i] : ~HP[i];
      e.vs = (py >= VS0[i] && py < VS1[i]) ? VP[i] : ~VP[i];
      e.fs = (px == 0) && (py == 0);
    end
    return e;
  endfunction

  task automatic check(string what, int act, int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", what, act, expv, $time);
    end
  endtask

  task automatic cmp(int i, string note);
    exp_t e;
    e = model(cnt, i);
    check($sformatf("R1 x inst%0d %s", i, note), gx[i], e.x);
    check($sformatf("R2 y inst%0d %s", i, note), gy[i], e.y);
    check($sformatf("R4 de inst%0d %s", i, note), int'(de[i]), int'(e.de));
    check($sformatf("R5 hs inst%0d %s", i, note), int'(hs[i]), int'(e.hs));
    check($sformatf("R6 vs inst%0d %s", i, note), int'(vs[i]), int'(e.vs));
    check($sformatf("R7 fs inst%0d %s", i, note), int'(fs[i]), int'(e.fs));
  endtask

  // R3: outputs held at reset values; depth-0 copy shows decode of (0,0) with R9 inversion
  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) cmp(i, "R3 power-on reset");
    check("R9 depth0 hs idle high while reset (active-low)", int'(hs[1]), 1);
    check("R3 default de idle in reset", int'(de[0]), 0);
    rst_n = 1'b1;
  endtask

  // R1 R4 R5 R8: default geometry over three lines, incl. 799/800, 816..847, 1023 wrap
  task automatic test_default_lines();
    repeat (3 * 1024 + 20) begin
      @(negedge clk);
      cmp(0, "default depth1 R8");
    end
  endtask

  // R2 R6 R7 R8 R9: small frames, depths 0/2/4, vertical wrap several times
  task automatic test_small_frames();
    repeat (1000) begin
      @(negedge clk);
      for (int i = 1; i < 4; i++) cmp(i, "small frame R8 R9");
    end
  endtask

  // R10: alternative 1000x500 frame, wrap after 999
  task automatic test_alt_frame();
    repeat (2100) begin
      @(negedge clk);
      cmp(4, "R10 1000x500 depth3");
    end
  endtask

  // R3: asynchronous clear mid-frame, then R8 idle refill after restart
  task automatic test_mid_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < N; i++) cmp(i, "R3 async mid-frame");
    @(negedge clk);
    for (int i = 0; i < N; i++) cmp(i, "R3 held");
    rst_n = 1'b1;
    repeat (600) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) cmp(i, "R8 refill after restart");
    end
  endtask

  initial begin
    test_reset();
    test_default_lines();
    test_small_frames();
    test_alt_frame();
    test_mid_reset();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule